// File: doc/BRIEF.md
# Page-Absent Fault Syndrome Generator

This block sits next to the instruction-side and data-side translation lookaside buffers. In every cycle it may be offered one instruction fetch and one data-side access. Each access arrives with the present flag of the translation entry it hit, the region identifier and page size of the region register it used, and its virtual address. The block decides whether a page-absent fault must be raised. A fault is raised only if the access class has its translation switched on and the entry is marked absent.

When a fault is raised, the block records a syndrome in registers, one cycle after the access. The syndrome has three parts:
- the faulting address;
- a default translation-information word built from the region register;
- a 64-bit status word that describes the kind of access and the instruction slot.

The syndrome stays unchanged until the next fault. The block also drives the fixed vector offset for this fault class, so that the trap logic can route to the handler.

Top module: `page_absent_trap`

## Requirements
- R1: A fault can be raised only by a requesting access whose present flag is 0. An access with present = 1 never faults.
- R2: A fetch can fault only while `xlat_inst_en` is 1. Loads (kind 0), stores (kind 1), semaphores (kind 2) and non-access operations (kind 3) can fault only while `xlat_data_en` is 1. Register-stack fills (kind 4) and spills (kind 5) can fault only while `xlat_stack_en` is 1.
- R3: `trap_vector` always reads 16'h5000.
- R4: The translation-information word carries the referenced region id in bits 31:8 and the page size in bits 7:2. All other bits are 0.
- R5: A native fault records the access address unchanged. A fetch in legacy 32-bit mode records the address with bits 3:0 cleared and bits 63:32 cleared.
- R6: Data status word fields:
  - read = bit 34 (set for loads, semaphores and fills);
  - write = bit 33 (set for stores, semaphores and spills);
  - non-access = bit 35 (set for kind 3);
  - register-stack = bit 37 (set for kinds 4 and 5);
  - slot = bits 42:41;
  - deferral = bit 43;
  - ni = bit 39, ir = bit 38, sp = bit 36;
  - bits 3:0 hold `dm_nacode` for kind 3 and are 0 otherwise.
  - Every other bit is 0.
- R7: For register-stack fills and spills, status bit 43 is 0 whatever `dm_ed` is.
- R8: For legacy data accesses, status bits 3:0, 35 through 39, and 41 through 43 are all 0. For legacy fetches, bits 42:41 and bit 39 are 0.
- R9: For a fetch fault, status bit 32 is set, bits 42:41 hold the fetch slot, and bit 39 holds `if_ni`. All other bits are 0.
- R10: When a fetch fault and a data fault occur in the same cycle, the fetch fault is recorded and `trap_is_fetch` is 1.
- R11: `trap_o` pulses high in the cycle after the faulting access. The syndrome outputs change only on that edge and otherwise hold their value. Reset clears all of them to 0.
- R12: Data kinds 6 and 7 never fault and leave the syndrome unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_req | input | 1 | Fetch access valid |
| if_legacy | input | 1 | Fetch is in legacy 32-bit mode |
| if_slot | input | 2 | Slot of the fetched instruction |
| if_ni | input | 1 | Fetch nested-interruption flag |
| if_addr | input | VA_W | Fetch virtual address |
| if_present | input | 1 | Present flag of the fetch translation |
| if_rid | input | RID_W | Region id used by the fetch |
| if_ps | input | PS_W | Page size of the fetch region |
| dm_req | input | 1 | Data access valid |
| dm_kind | input | 3 | Data access kind (0 to 5, see R2) |
| dm_legacy | input | 1 | Data access is a legacy 32-bit reference |
| dm_nacode | input | 4 | Non-access operation type |
| dm_slot | input | 2 | Slot of the data instruction |
| dm_ed | input | 1 | Deferral flag of the data access |
| dm_ni | input | 1 | Data nested-interruption flag |
| dm_ir | input | 1 | Data incomplete-frame flag |
| dm_sp | input | 1 | Data speculative flag |
| dm_addr | input | VA_W | Data virtual address |
| dm_present | input | 1 | Present flag of the data translation |
| dm_rid | input | RID_W | Region id used by the data access |
| dm_ps | input | PS_W | Page size of the data region |
| xlat_inst_en | input | 1 | Instruction translation enabled |
| xlat_data_en | input | 1 | Data translation enabled |
| xlat_stack_en | input | 1 | Register-stack translation enabled |
| trap_o | output | 1 | One-cycle fault pulse |
| trap_is_fetch | output | 1 | Recorded fault came from a fetch |
| trap_vaddr | output | VA_W | Recorded faulting address |
| trap_xinfo | output | 64 | Recorded translation-information word |
| trap_status | output | 64 | Recorded status word |
| trap_vector | output | 16 | Vector offset, constant 16'h5000 |

## Verification
The bench targets the following corner cases:

| Corner case | What a faulty design would do |
|---|---|
| A class whose enable is off while another enable is on | Raise a fault from the wrong enable bit |
| A legacy fetch with high and low address bits set | Record an unaligned address or leave upper bits set |
| A stack fill with deferral set | Let the deferral bit leak into the status |
| A legacy data reference with every flag raised | Show non-zero slot or flag fields |
| A simultaneous fetch fault and data fault | Record the data side |
| A reserved kind with an absent page | Raise a fault or disturb the held syndrome |

Random traffic with frequent absent pages also checks that the syndrome holds through cycles without a fault.

// File: rtl/pgnp_pkg.sv
package pgnp_pkg;

    // data-side access classes; the encoding is visible at the port
    typedef enum logic [2:0] {
        ACC_LOAD    = 3'd0,
        ACC_STORE   = 3'd1,
        ACC_SEMA    = 3'd2,
        ACC_NONACC  = 3'd3,
        ACC_RSFILL  = 3'd4,
        ACC_RSSPILL = 3'd5,
        ACC_RSV6    = 3'd6,
        ACC_RSV7    = 3'd7
    } acc_kind_e;

    localparam logic [15:0] PNP_VECTOR = 16'h5000;

    // status word bit positions
    localparam int ST_CODE_LSB = 0;
    localparam int ST_X        = 32;
    localparam int ST_W        = 33;
    localparam int ST_R        = 34;
    localparam int ST_NA       = 35;
    localparam int ST_SP       = 36;
    localparam int ST_RS       = 37;
    localparam int ST_IR       = 38;
    localparam int ST_NI       = 39;
    localparam int ST_SO       = 40;
    localparam int ST_EI_LSB   = 41;
    localparam int ST_ED       = 43;

    // translation-information word positions
    localparam int XI_PS_LSB  = 2;
    localparam int XI_KEY_LSB = 8;

    localparam int LEGACY_AW    = 32;
    localparam int FETCH_ALIGN  = 4;

    typedef struct packed {
        logic [3:0] code;
        logic       x;
        logic       w;
        logic       r;
        logic       na;
        logic       sp;
        logic       rs;
        logic       ir;
        logic       ni;
        logic       so;
        logic [1:0] ei;
        logic       ed;
    } status_f_t;

    function automatic logic [63:0] status_pack(status_f_t f);
        logic [63:0] w;
        w = '0;
        w[ST_CODE_LSB +: 4] = f.code;
        w[ST_X]             = f.x;
        w[ST_W]             = f.w;
        w[ST_R]             = f.r;
        w[ST_NA]            = f.na;
        w[ST_SP]            = f.sp;
        w[ST_RS]            = f.rs;
        w[ST_IR]            = f.ir;
        w[ST_NI]            = f.ni;
        w[ST_SO]            = f.so;
        w[ST_EI_LSB +: 2]   = f.ei;
        w[ST_ED]            = f.ed;
        return w;
    endfunction

    function automatic logic kind_is_stack(acc_kind_e k);
        return (k == ACC_RSFILL) || (k == ACC_RSSPILL);
    endfunction

    function automatic logic kind_is_plain(acc_kind_e k);
        return (k == ACC_LOAD) || (k == ACC_STORE) ||
               (k == ACC_SEMA) || (k == ACC_NONACC);
    endfunction

endpackage

// File: rtl/pgnp_gate.sv
module pgnp_gate
    import pgnp_pkg::*;
(
    input  logic       if_req,
    input  logic       if_present,
    input  logic       dm_req,
    input  logic [2:0] dm_kind,
    input  logic       dm_present,
    input  logic       xlat_inst_en,
    input  logic       xlat_data_en,
    input  logic       xlat_stack_en,
    output logic       raise,
    output logic       pick_fetch
);
    acc_kind_e kind;
    logic      fetch_hit;
    logic      data_hit;
    logic      data_xlat_on;

    always_comb begin
        kind         = acc_kind_e'(dm_kind);
        data_xlat_on = kind_is_stack(kind) ? xlat_stack_en
                     : (kind_is_plain(kind) ? xlat_data_en : 1'b0);
        fetch_hit    = if_req && !if_present && xlat_inst_en;
        data_hit     = dm_req && !dm_present && data_xlat_on;
        raise        = fetch_hit || data_hit;
        pick_fetch   = fetch_hit;
    end
endmodule

// File: rtl/pgnp_compose.sv
module pgnp_compose
    import pgnp_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int RID_W = 24,
    parameter int PS_W  = 6
) (
    input  logic             pick_fetch,
    input  logic             if_legacy,
    input  logic [1:0]       if_slot,
    input  logic             if_ni,
    input  logic [VA_W-1:0]  if_addr,
    input  logic [RID_W-1:0] if_rid,
    input  logic [PS_W-1:0]  if_ps,
    input  logic [2:0]       dm_kind,
    input  logic             dm_legacy,
    input  logic [3:0]       dm_nacode,
    input  logic [1:0]       dm_slot,
    input  logic             dm_ed,
    input  logic             dm_ni,
    input  logic             dm_ir,
    input  logic             dm_sp,
    input  logic [VA_W-1:0]  dm_addr,
    input  logic [RID_W-1:0] dm_rid,
    input  logic [PS_W-1:0]  dm_ps,
    output logic [VA_W-1:0]  syn_addr,
    output logic [63:0]      syn_xinfo,
    output logic [63:0]      syn_status
);
    localparam int LOW_KEEP = LEGACY_AW - FETCH_ALIGN;

    logic [VA_W-1:0] legacy_fetch_addr;
    status_f_t       fs;
    status_f_t       ds;
    acc_kind_e       kind;
    logic [RID_W-1:0] rid_sel;
    logic [PS_W-1:0]  ps_sel;

    // legacy fetch: align down and zero the upper half
    generate
        if (VA_W > LEGACY_AW) begin : g_wide
            assign legacy_fetch_addr = {{(VA_W-LEGACY_AW){1'b0}},
                                        if_addr[LEGACY_AW-1:FETCH_ALIGN],
                                        {FETCH_ALIGN{1'b0}}};
        end else begin : g_narrow
            assign legacy_fetch_addr = {if_addr[VA_W-1:FETCH_ALIGN],
                                        {FETCH_ALIGN{1'b0}}};
        end
    endgenerate

    always_comb begin
        fs    = '0;
        fs.x  = 1'b1;
        fs.ei = if_legacy ? 2'b00 : if_slot;
        fs.ni = if_legacy ? 1'b0 : if_ni;
    end

    always_comb begin
        kind = acc_kind_e'(dm_kind);
        ds   = '0;
        ds.r = (kind == ACC_LOAD) || (kind == ACC_SEMA) || (kind == ACC_RSFILL);
        ds.w = (kind == ACC_STORE) || (kind == ACC_SEMA) || (kind == ACC_RSSPILL);
        if (!dm_legacy) begin
            ds.na   = (kind == ACC_NONACC);
            ds.code = (kind == ACC_NONACC) ? dm_nacode : 4'd0;
            ds.rs   = kind_is_stack(kind);
            ds.ed   = dm_ed && !kind_is_stack(kind);
            ds.ei   = dm_slot;
            ds.ni   = dm_ni;
            ds.ir   = dm_ir;
            ds.sp   = dm_sp;
        end
    end

    always_comb begin
        rid_sel   = pick_fetch ? if_rid : dm_rid;
        ps_sel    = pick_fetch ? if_ps  : dm_ps;
        syn_xinfo = '0;
        syn_xinfo[XI_KEY_LSB +: RID_W] = rid_sel;
        syn_xinfo[XI_PS_LSB  +: PS_W]  = ps_sel;
        if (pick_fetch) begin
            syn_addr   = if_legacy ? legacy_fetch_addr : if_addr;
            syn_status = status_pack(fs);
        end else begin
            syn_addr   = dm_addr;
            syn_status = status_pack(ds);
        end
    end
endmodule

// File: rtl/pgnp_hold.sv
module pgnp_hold #(
    parameter int VA_W = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raise,
    input  logic            pick_fetch,
    input  logic [VA_W-1:0] syn_addr,
    input  logic [63:0]     syn_xinfo,
    input  logic [63:0]     syn_status,
    output logic            trap_o,
    output logic            trap_is_fetch,
    output logic [VA_W-1:0] trap_vaddr,
    output logic [63:0]     trap_xinfo,
    output logic [63:0]     trap_status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_o        <= 1'b0;
            trap_is_fetch <= 1'b0;
            trap_vaddr    <= '0;
            trap_xinfo    <= '0;
            trap_status   <= '0;
        end else begin
            trap_o <= raise;
            if (raise) begin
                trap_is_fetch <= pick_fetch;
                trap_vaddr    <= syn_addr;
                trap_xinfo    <= syn_xinfo;
                trap_status   <= syn_status;
            end
        end
    end
endmodule

// File: rtl/page_absent_trap.sv
module page_absent_trap
    import pgnp_pkg::*;
#(
    parameter int VA_W  = 64,
    parameter int RID_W = 24,
    parameter int PS_W  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             if_req,
    input  logic             if_legacy,
    input  logic [1:0]       if_slot,
    input  logic             if_ni,
    input  logic [VA_W-1:0]  if_addr,
    input  logic             if_present,
    input  logic [RID_W-1:0] if_rid,
    input  logic [PS_W-1:0]  if_ps,
    input  logic             dm_req,
    input  logic [2:0]       dm_kind,
    input  logic             dm_legacy,
    input  logic [3:0]       dm_nacode,
    input  logic [1:0]       dm_slot,
    input  logic             dm_ed,
    input  logic             dm_ni,
    input  logic             dm_ir,
    input  logic             dm_sp,
    input  logic [VA_W-1:0]  dm_addr,
    input  logic             dm_present,
    input  logic [RID_W-1:0] dm_rid,
    input  logic [PS_W-1:0]  dm_ps,
    input  logic             xlat_inst_en,
    input  logic             xlat_data_en,
    input  logic             xlat_stack_en,
    output logic             trap_o,
    output logic             trap_is_fetch,
    output logic [VA_W-1:0]  trap_vaddr,
    output logic [63:0]      trap_xinfo,
    output logic [63:0]      trap_status,
    output logic [15:0]      trap_vector
);
    logic            raise;
    logic            pick_fetch;
    logic [VA_W-1:0] syn_addr;
    logic [63:0]     syn_xinfo;
    logic [63:0]     syn_status;

    assign trap_vector = PNP_VECTOR;

    pgnp_gate u_gate (
        .if_req        (if_req),
        .if_present    (if_present),
        .dm_req        (dm_req),
        .dm_kind       (dm_kind),
        .dm_present    (dm_present),
        .xlat_inst_en  (xlat_inst_en),
        .xlat_data_en  (xlat_data_en),
        .xlat_stack_en (xlat_stack_en),
        .raise         (raise),
        .pick_fetch    (pick_fetch)
    );

    pgnp_compose #(.VA_W(VA_W), .RID_W(RID_W), .PS_W(PS_W)) u_compose (
        .pick_fetch (pick_fetch),
        .if_legacy  (if_legacy),
        .if_slot    (if_slot),
        .if_ni      (if_ni),
        .if_addr    (if_addr),
        .if_rid     (if_rid),
        .if_ps      (if_ps),
        .dm_kind    (dm_kind),
        .dm_legacy  (dm_legacy),
        .dm_nacode  (dm_nacode),
        .dm_slot    (dm_slot),
        .dm_ed      (dm_ed),
        .dm_ni      (dm_ni),
        .dm_ir      (dm_ir),
        .dm_sp      (dm_sp),
        .dm_addr    (dm_addr),
        .dm_rid     (dm_rid),
        .dm_ps      (dm_ps),
        .syn_addr   (syn_addr),
        .syn_xinfo  (syn_xinfo),
        .syn_status (syn_status)
    );

    pgnp_hold #(.VA_W(VA_W)) u_hold (
        .clk           (clk),
        .rst           (rst),
        .raise         (raise),
        .pick_fetch    (pick_fetch),
        .syn_addr      (syn_addr),
        .syn_xinfo     (syn_xinfo),
        .syn_status    (syn_status),
        .trap_o        (trap_o),
        .trap_is_fetch (trap_is_fetch),
        .trap_vaddr    (trap_vaddr),
        .trap_xinfo    (trap_xinfo),
        .trap_status   (trap_status)
    );
endmodule

// File: rtl/pgnp_checker.sv
module pgnp_checker #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            if_req,
    input logic            if_legacy,
    input logic            if_present,
    input logic            xlat_inst_en,
    input logic            dm_req,
    input logic [2:0]      dm_kind,
    input logic            dm_present,
    input logic            trap_o,
    input logic            trap_is_fetch,
    input logic [VA_W-1:0] trap_vaddr,
    input logic [63:0]     trap_xinfo,
    input logic [63:0]     trap_status
);
    a_r1_needs_absent: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> $past((if_req && !if_present) || (dm_req && !dm_present)));

    a_r12_reserved_kind_quiet: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !trap_is_fetch) |-> ($past(dm_kind) < 3'd6));

    a_r4_xinfo_clean: assert property (@(posedge clk) disable iff (rst)
        (trap_xinfo[63:32] == 32'd0) && (trap_xinfo[1:0] == 2'd0));

    a_r7_stack_no_defer: assert property (@(posedge clk) disable iff (rst)
        (trap_o && !trap_is_fetch && ($past(dm_kind) inside {3'd4, 3'd5}))
            |-> !trap_status[43]);

    a_r9_fetch_status: assert property (@(posedge clk) disable iff (rst)
        (trap_o && trap_is_fetch) |->
            (trap_status[32] && !trap_status[33] && !trap_status[34] &&
             trap_status[38:35] == 4'd0 && !trap_status[40] && !trap_status[43] &&
             trap_status[3:0] == 4'd0));

    a_r8_legacy_fetch_align: assert property (@(posedge clk) disable iff (rst)
        (trap_o && trap_is_fetch && $past(if_legacy)) |->
            (trap_vaddr[3:0] == 4'd0 && trap_vaddr[VA_W-1:32] == '0));

    a_r10_fetch_first: assert property (@(posedge clk) disable iff (rst)
        $past(if_req && !if_present && xlat_inst_en) |-> (trap_o && trap_is_fetch));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !trap_o |-> ($stable(trap_vaddr) && $stable(trap_xinfo) &&
                     $stable(trap_status) && $stable(trap_is_fetch)));
endmodule

bind page_absent_trap pgnp_checker #(.VA_W(VA_W)) u_pgnp_chk (
    .clk           (clk),
    .rst           (rst),
    .if_req        (if_req),
    .if_legacy     (if_legacy),
    .if_present    (if_present),
    .xlat_inst_en  (xlat_inst_en),
    .dm_req        (dm_req),
    .dm_kind       (dm_kind),
    .dm_present    (dm_present),
    .trap_o        (trap_o),
    .trap_is_fetch (trap_is_fetch),
    .trap_vaddr    (trap_vaddr),
    .trap_xinfo    (trap_xinfo),
    .trap_status   (trap_status)
);

// File: tb/tb_page_absent_trap.sv
`timescale 1ns/1ps
module tb_page_absent_trap;
    localparam int VA_W  = 64;
    localparam int RID_W = 24;
    localparam int PS_W  = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             if_req, if_legacy, if_ni, if_present;
    logic [1:0]       if_slot;
    logic [VA_W-1:0]  if_addr;
    logic [RID_W-1:0] if_rid;
    logic [PS_W-1:0]  if_ps;
    logic             dm_req, dm_legacy, dm_ed, dm_ni, dm_ir, dm_sp, dm_present;
    logic [2:0]       dm_kind;
    logic [3:0]       dm_nacode;
    logic [1:0]       dm_slot;
    logic [VA_W-1:0]  dm_addr;
    logic [RID_W-1:0] dm_rid;
    logic [PS_W-1:0]  dm_ps;
    logic             xlat_inst_en, xlat_data_en, xlat_stack_en;
    logic             trap_o, trap_is_fetch;
    logic [VA_W-1:0]  trap_vaddr;
    logic [63:0]      trap_xinfo, trap_status;
    logic [15:0]      trap_vector;

    always #4 clk = ~clk;

    page_absent_trap #(.VA_W(VA_W), .RID_W(RID_W), .PS_W(PS_W)) dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic            h_fetch;
    logic [63:0]     h_addr, h_xinfo, h_status;

    function automatic logic [63:0] m_xinfo(logic [RID_W-1:0] rid, logic [PS_W-1:0] ps);
        logic [63:0] v = '0;
        v[31:8] = rid;
        v[7:2]  = ps;
        return v;
    endfunction

    function automatic logic [63:0] m_fetch_status(logic leg, logic [1:0] slot, logic ni);
        logic [63:0] s = '0;
        s[32] = 1'b1;
        if (!leg) begin
            s[42:41] = slot;
            s[39]    = ni;
        end
        return s;
    endfunction

    function automatic logic [63:0] m_data_status();
        logic [63:0] s = '0;
        logic stack;
        stack = (dm_kind == 3'd4) || (dm_kind == 3'd5);
        s[34] = (dm_kind == 3'd0) || (dm_kind == 3'd2) || (dm_kind == 3'd4);
        s[33] = (dm_kind == 3'd1) || (dm_kind == 3'd2) || (dm_kind == 3'd5);
        if (!dm_legacy) begin
            if (dm_kind == 3'd3) begin
                s[35]  = 1'b1;
                s[3:0] = dm_nacode;
            end
            s[37]    = stack;
            s[43]    = dm_ed && !stack;
            s[42:41] = dm_slot;
            s[39]    = dm_ni;
            s[38]    = dm_ir;
            s[36]    = dm_sp;
        end
        return s;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        if_req = 0; if_legacy = 0; if_ni = 0; if_present = 1; if_slot = 0;
        if_addr = '0; if_rid = '0; if_ps = '0;
        dm_req = 0; dm_legacy = 0; dm_ed = 0; dm_ni = 0; dm_ir = 0; dm_sp = 0;
        dm_present = 1; dm_kind = 0; dm_nacode = 0; dm_slot = 0;
        dm_addr = '0; dm_rid = '0; dm_ps = '0;
        xlat_inst_en = 1; xlat_data_en = 1; xlat_stack_en = 1;
    endtask

    // inputs are already set; apply one edge and check
    task automatic step(string ftag, string stag);
        logic f_hit, d_hit, d_on, trap;
        f_hit = if_req && !if_present && xlat_inst_en;
        d_on  = (dm_kind <= 3'd3) ? xlat_data_en
              : ((dm_kind <= 3'd5) ? xlat_stack_en : 1'b0);
        d_hit = dm_req && !dm_present && d_on;
        trap  = f_hit || d_hit;
        if (trap) begin
            h_fetch = f_hit;
            if (f_hit) begin
                h_addr   = if_legacy ? {32'd0, if_addr[31:4], 4'd0} : if_addr;
                h_xinfo  = m_xinfo(if_rid, if_ps);
                h_status = m_fetch_status(if_legacy, if_slot, if_ni);
            end else begin
                h_addr   = dm_addr;
                h_xinfo  = m_xinfo(dm_rid, dm_ps);
                h_status = m_data_status();
            end
        end
        @(posedge clk);
        #1;
        chk(ftag, {63'd0, trap_o}, {63'd0, trap});
        chk(ftag, {63'd0, trap_is_fetch}, {63'd0, h_fetch});
        chk(trap ? stag : "R11", trap_status, h_status);
        chk(trap ? "R5" : "R11", trap_vaddr, h_addr);
        chk(trap ? "R4" : "R11", trap_xinfo, h_xinfo);
        chk("R3", {48'd0, trap_vector}, 64'h5000);
        @(negedge clk);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1F2E3D4C);
        idle();
        rst = 1;
        h_fetch = 0; h_addr = '0; h_xinfo = '0; h_status = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11", {63'd0, trap_o}, 64'd0);
        chk("R11", trap_status, 64'd0);
        chk("R11", trap_vaddr, 64'd0);
        @(negedge clk);
        rst = 0;

        // R9 native fetch fault
        idle(); if_req = 1; if_present = 0; if_slot = 2; if_ni = 1;
        if_addr = 64'hFFFF_0000_1234_5670; if_rid = 24'hABCDEF; if_ps = 6'd14;
        step("R1", "R9");
        // R11 hold on quiet cycle
        idle(); step("R11", "R11");
        // R8 legacy fetch alignment
        idle(); if_req = 1; if_present = 0; if_legacy = 1; if_slot = 3; if_ni = 1;
        if_addr = 64'hDEAD_BEEF_8765_432F; if_rid = 24'h000123; if_ps = 6'd12;
        step("R1", "R8");
        // R2 fetch with instruction translation off
        idle(); if_req = 1; if_present = 0; xlat_inst_en = 0; step("R2", "R2");
        // R2 load with data translation off, stack on
        idle(); dm_req = 1; dm_present = 0; dm_kind = 0; xlat_data_en = 0; step("R2", "R2");
        // R2 and R7: fill with data off, stack on, deferral set
        idle(); dm_req = 1; dm_present = 0; dm_kind = 4; xlat_data_en = 0; dm_ed = 1;
        dm_slot = 1; dm_addr = 64'h0000_7777_0000_0040; dm_rid = 24'h55AA55; dm_ps = 6'd16;
        step("R2", "R7");
        // R2 spill with stack off
        idle(); dm_req = 1; dm_present = 0; dm_kind = 5; xlat_stack_en = 0; step("R2", "R2");
        // R6 non-access code
        idle(); dm_req = 1; dm_present = 0; dm_kind = 3; dm_nacode = 4'hA; dm_ed = 1;
        dm_sp = 1; dm_addr = 64'h1111_2222_3333_4444; dm_rid = 24'h010203; dm_ps = 6'd20;
        step("R1", "R6");
        // R8 legacy data store with all flags raised
        idle(); dm_req = 1; dm_present = 0; dm_kind = 1; dm_legacy = 1; dm_ed = 1;
        dm_ni = 1; dm_ir = 1; dm_sp = 1; dm_slot = 3; dm_nacode = 4'hF;
        dm_addr = 64'h0000_0000_89AB_CDEF; step("R1", "R8");
        // R10 simultaneous faults
        idle(); if_req = 1; if_present = 0; if_addr = 64'h4000; if_rid = 24'h7; if_ps = 6'd13;
        dm_req = 1; dm_present = 0; dm_kind = 2; dm_addr = 64'h9999; dm_rid = 24'h8;
        step("R10", "R10");
        // R12 reserved kinds
        idle(); dm_req = 1; dm_present = 0; dm_kind = 6; dm_addr = 64'h5; step("R12", "R12");
        idle(); dm_req = 1; dm_present = 0; dm_kind = 7; dm_addr = 64'h6; step("R12", "R12");
        // R1 present pages never fault
        idle(); if_req = 1; dm_req = 1; dm_kind = 0; step("R1", "R1");

        for (int i = 0; i < 800; i++) begin
            if_req       = $urandom_range(0, 1);
            if_legacy    = $urandom_range(0, 3) == 0;
            if_ni        = $urandom_range(0, 1);
            if_present   = $urandom_range(0, 2) == 0;
            if_slot      = 2'($urandom);
            if_addr      = {$urandom, $urandom};
            if_rid       = RID_W'($urandom);
            if_ps        = PS_W'($urandom);
            dm_req       = $urandom_range(0, 1);
            dm_legacy    = $urandom_range(0, 3) == 0;
            dm_ed        = $urandom_range(0, 1);
            dm_ni        = $urandom_range(0, 1);
            dm_ir        = $urandom_range(0, 1);
            dm_sp        = $urandom_range(0, 1);
            dm_present   = $urandom_range(0, 2) == 0;
            dm_kind      = 3'($urandom);
            dm_nacode    = 4'($urandom);
            dm_slot      = 2'($urandom);
            dm_addr      = {$urandom, $urandom};
            dm_rid       = RID_W'($urandom);
            dm_ps        = PS_W'($urandom);
            xlat_inst_en  = $urandom_range(0, 4) != 0;
            xlat_data_en  = $urandom_range(0, 4) != 0;
            xlat_stack_en = $urandom_range(0, 4) != 0;
            step("R1", "R6");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule